// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds a small bank of hardware semaphores that two independent ports (left and right) share to reserve common resources. The semaphores are separate from any data memory. A port claims a semaphore by writing a zero to it and gives it up, or withdraws a pending claim, by writing a one. Reading a semaphore returns zero to the port that holds it and one to every other case, replicated across the whole data word.

Each semaphore remembers a pending claim from each side. When the holder releases while the other side has a claim outstanding, ownership moves to the waiting side at that same clock edge, so the waiting side's next poll already sees success. When both sides claim a free semaphore in the same cycle, the left side wins and the right side's claim stays pending. Read data is registered and held until the same port reads again, so activity from the other port cannot disturb a value already returned.

Top module: `sem_bank`

## Requirements
- R1: There are eight semaphores, selected by the 3-bit address of the accessing port; each semaphore's state is independent of the others.
- R2: A port accesses the bank only while its select input `*_sel_n` is 0 and its memory enable `*_mem_en_n` is 1; any other combination has no effect on semaphore state and does not update that port's read data.
- R3: A write (`*_wr_n` = 0) uses only data bit 0: 0 places a claim, 1 releases or withdraws; bits above bit 0 have no effect.
- R4: A claim on a free semaphore makes the claimant the owner at the next clock edge; afterwards the owner reads 0 and the other port reads 1 at that address.
- R5: Only the owner can end its ownership; a non-owner writing 1 clears just its own pending claim, and a non-owner writing 0 only records a pending claim.
- R6: When the owner writes 1 while the other side has a pending claim, the other side becomes owner at the same edge; with no pending claim the semaphore becomes free and reads 1 on both ports.
- R7: A read (`*_wr_n` = 1) returns the semaphore's value as it stood before that clock edge, on every data bit (all zeros for owned-by-me, all ones otherwise), one cycle after the request, and holds it until the same port reads again.
- R8: If both ports claim the same free semaphore in the same cycle, the left port becomes owner and the right port's claim remains pending.
- R9: After reset all semaphores are free with no pending claims, and both read-data outputs are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_mem_en_n | input | 1 | Left memory enable, must be 1 for a semaphore access |
| l_wr_n | input | 1 | Left write strobe, 0 = write, 1 = read |
| l_addr | input | 3 | Left semaphore index |
| l_wdata | input | 16 | Left write data (bit 0 used) |
| l_rdata | output | 16 | Left registered read data |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_mem_en_n | input | 1 | Right memory enable, must be 1 for a semaphore access |
| r_wr_n | input | 1 | Right write strobe, 0 = write, 1 = read |
| r_addr | input | 3 | Right semaphore index |
| r_wdata | input | 16 | Right write data (bit 0 used) |
| r_rdata | output | 16 | Right registered read data |

## Verification
The embedded assertions check on every cycle that a claim on an unheld semaphore is granted, that ownership survives anything but the owner's own release, that a release hands over to a pending claimant or frees the semaphore, that same-cycle claims resolve to the left, and that read data stays put between reads. Only the bench's scenarios can show what a port actually reads back at each address after reset, that accesses without a proper select are ignored and that upper write-data bits do nothing, and that reads and writes arriving in the same cycle from opposite ports behave as a reference model of the rules predicts across long mixed sequences over all eight addresses.

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int DATA_W = 16,
  parameter int N_SEM  = 8,
  parameter int ADDR_W = $clog2(N_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_mem_en_n,
  input  logic              l_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel_n,
  input  logic              r_mem_en_n,
  input  logic              r_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);

  logic l_acc, r_acc, l_wr, r_wr, l_rd, r_rd;
  logic [N_SEM-1:0] own_l, own_r, req_l, req_r;

  assign l_acc = !l_sel_n && l_mem_en_n;
  assign r_acc = !r_sel_n && r_mem_en_n;
  assign l_wr  = l_acc && !l_wr_n;
  assign r_wr  = r_acc && !r_wr_n;
  assign l_rd  = l_acc && l_wr_n;
  assign r_rd  = r_acc && r_wr_n;

  wire unused_upper = &{1'b0, l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  for (genvar i = 0; i < N_SEM; i++) begin : g_sem
    logic l_hit, r_hit, l_claim, r_claim, l_rel, r_rel;
    logic nql, nqr, nol, nor_;

    assign l_hit   = l_wr && (l_addr == ADDR_W'(i));
    assign r_hit   = r_wr && (r_addr == ADDR_W'(i));
    assign l_claim = l_hit && !l_wdata[0];
    assign r_claim = r_hit && !r_wdata[0];
    assign l_rel   = l_hit && l_wdata[0];
    assign r_rel   = r_hit && r_wdata[0];
    assign nql     = l_hit ? !l_wdata[0] : req_l[i];
    assign nqr     = r_hit ? !r_wdata[0] : req_r[i];

    always_comb begin
      nol  = 1'b0;
      nor_ = 1'b0;
      if (own_l[i] && nql)      nol  = 1'b1;
      else if (own_r[i] && nqr) nor_ = 1'b1;
      else if (nql)             nol  = 1'b1;
      else if (nqr)             nor_ = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_l[i] <= 1'b0;
        req_r[i] <= 1'b0;
        own_l[i] <= 1'b0;
        own_r[i] <= 1'b0;
      end else begin
        req_l[i] <= nql;
        req_r[i] <= nqr;
        own_l[i] <= nol;
        own_r[i] <= nor_;
      end
    end

    assert_grant_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (l_claim && !own_r[i]) |=> own_l[i]);
    assert_grant_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (r_claim && !own_l[i] && !l_claim) |=> own_r[i]);
    assert_hold_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[i] && !l_rel) |=> own_l[i]);
    assert_hold_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_r[i] && !r_rel) |=> own_r[i]);
    assert_handoff_to_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[i] && l_rel && (req_r[i] || r_claim) && !r_rel) |=> own_r[i]);
    assert_handoff_to_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_r[i] && r_rel && (req_l[i] || l_claim) && !l_rel) |=> own_l[i]);
    assert_free_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[i] && l_rel && !req_r[i] && !r_hit) |=> (!own_l[i] && !own_r[i]));
    assert_tie_left_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l[i] && !own_r[i] && l_claim && r_claim) |=> (own_l[i] && req_r[i]));
    assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(own_l[i] && own_r[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '1;
      r_rdata <= '1;
    end else begin
      if (l_rd) l_rdata <= {DATA_W{!own_l[l_addr]}};
      if (r_rd) r_rdata <= {DATA_W{!own_r[r_addr]}};
    end
  end

  assert_left_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(l_rdata));
  assert_right_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd |=> $stable(r_rdata));
  assert_left_read_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0) || (l_rdata == '1));
  assert_idle_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_wr && !r_wr) |=> ($stable(own_l) && $stable(own_r) && $stable(req_l) && $stable(req_r)));

endmodule

// File: tb/sem_bank_bench.sv
`timescale 1ns/1ps
module sem_bank_bench;
  localparam int DW = 16;
  localparam int NS = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic l_sel_n, l_mem_en_n, l_wr_n, r_sel_n, r_mem_en_n, r_wr_n;
  logic [2:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  sem_bank u_sem_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_mem_en_n(l_mem_en_n), .l_wr_n(l_wr_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_mem_en_n(r_mem_en_n), .r_wr_n(r_wr_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  int vecs = 0, errs = 0;
  bit done = 0;
  int m_own [NS];
  bit m_ql [NS], m_qr [NS];
  logic [DW-1:0] exp_l, exp_r;

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic ls, input logic le, input logic lw, input logic [2:0] la, input logic [DW-1:0] ld,
                     input logic rs, input logic re, input logic rw, input logic [2:0] ra, input logic [DW-1:0] rd,
                     input string tag);
    bit lacc, racc;
    l_sel_n = ls; l_mem_en_n = le; l_wr_n = lw; l_addr = la; l_wdata = ld;
    r_sel_n = rs; r_mem_en_n = re; r_wr_n = rw; r_addr = ra; r_wdata = rd;
    lacc = !ls && le;
    racc = !rs && re;
    if (lacc && lw) exp_l = (m_own[la] == 1) ? '0 : '1;
    if (racc && rw) exp_r = (m_own[ra] == 2) ? '0 : '1;
    for (int i = 0; i < NS; i++) begin
      bit ql, qr;
      ql = m_ql[i];
      qr = m_qr[i];
      if (lacc && !lw && la == 3'(i)) ql = !ld[0];
      if (racc && !rw && ra == 3'(i)) qr = !rd[0];
      if (m_own[i] == 1 && ql)      m_own[i] = 1;
      else if (m_own[i] == 2 && qr) m_own[i] = 2;
      else if (ql)                  m_own[i] = 1;
      else if (qr)                  m_own[i] = 2;
      else                          m_own[i] = 0;
      m_ql[i] = ql;
      m_qr[i] = qr;
    end
    @(negedge clk);
    check(l_rdata, exp_l, {tag, " left"});
    check(r_rdata, exp_r, {tag, " right"});
  endtask

  task automatic idle(input string tag);
    cyc(1,1,1,0,'0, 1,1,1,0,'0, tag);
  endtask

  task automatic rd_both(input logic [2:0] a, input string tag);
    cyc(0,1,1,a,'0, 0,1,1,a,'0, tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NS; i++) begin m_own[i] = 0; m_ql[i] = 0; m_qr[i] = 0; end
    exp_l = '1; exp_r = '1;
    rst_n = 0;
    l_sel_n = 1; l_mem_en_n = 1; l_wr_n = 1; l_addr = 0; l_wdata = 0;
    r_sel_n = 1; r_mem_en_n = 1; r_wr_n = 1; r_addr = 0; r_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(l_rdata, '1, "R9 reset left rdata");
    check(r_rdata, '1, "R9 reset right rdata");
    for (int a = 0; a < NS; a++) rd_both(3'(a), "R9 reset read");

    // R4 claim free semaphore 3, upper data bits set (R3)
    cyc(0,1,0,3,16'hFFFE, 1,1,1,0,'0, "R3 claim with upper bits");
    rd_both(3, "R4 owner reads zero");
    check(l_rdata, '0, "R4 left owner");
    check(r_rdata, '1, "R4 right other");
    // R5 non-owner release and claim
    cyc(1,1,1,0,'0, 0,1,0,3,16'h0001, "R5 non-owner release");
    rd_both(3, "R5 ownership kept");
    cyc(1,1,1,0,'0, 0,1,0,3,16'hFFF0, "R5 non-owner claim");
    rd_both(3, "R5 pending only");
    check(r_rdata, '1, "R5 right still not owner");
    // R6 handoff
    cyc(0,1,0,3,16'h0001, 1,1,1,0,'0, "R6 owner release");
    rd_both(3, "R6 handoff");
    check(r_rdata, '0, "R6 right now owner");
    cyc(1,1,1,0,'0, 0,1,0,3,16'h0001, "R6 release no pending");
    rd_both(3, "R6 freed");
    check(l_rdata & r_rdata, '1, "R6 both read one");
    // R8 tie
    cyc(0,1,0,5,'0, 0,1,0,5,'0, "R8 same-cycle claim");
    rd_both(5, "R8 left wins");
    check(l_rdata, '0, "R8 left owner");
    // R7 hold: right reads (1) then left releases -> right owner, right rdata must hold
    cyc(1,1,1,0,'0, 0,1,1,5,'0, "R7 right read");
    cyc(0,1,0,5,16'h0001, 1,1,1,0,'0, "R7 hold across handoff");
    check(r_rdata, '1, "R7 right held value");
    rd_both(5, "R7 new read");
    // R2 ignored accesses
    cyc(0,0,0,6,'0, 1,0,0,6,'0, "R2 bad select write");
    rd_both(6, "R2 still free");
    cyc(0,0,1,5,'0, 0,0,1,5,'0, "R2 bad select read keeps rdata");
    // R1 independence
    for (int a = 0; a < NS; a++) cyc(0,1,0,3'(a),16'(a<<1), 1,1,1,0,'0, "R1 claim each");
    for (int a = 0; a < NS; a++) rd_both(3'(a), "R1 per-address read");
    for (int a = 0; a < NS; a += 2) cyc(0,1,0,3'(a),'1, 1,1,1,0,'0, "R1 release even");
    for (int a = 0; a < NS; a++) rd_both(3'(a), "R1 even free odd held");

    // mixed sweep: R4 R5 R6 R7 R8 against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      logic [2:0] kl, kr;
      logic [DW-1:0] dl, dr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      kl = lfsr[2:0]; kr = lfsr[5:3];
      dl = {lfsr[15:1], kl[0]};
      dr = {lfsr[14:0], kr[1]};
      cyc(kl == 0, kl != 7, kl[2] & kl[1], lfsr[8:6], dl,
          kr == 0, kr != 7, kr[2] & kr[1], lfsr[11:9], dr,
          "R4 R5 R6 R7 R8 sweep");
    end
    idle("R7 final idle");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule